// File: doc/BRIEF.md
# On-Chip RAM Address Window

This block lets a processor use 8 KB of local SRAM as plain memory by decoding a fixed 64 MB slice of its address space, 0x1C000000 through 0x1FFFFFFF. The SRAM is organised as two 4 KB halves. Every address in the slice folds onto one of them, so the whole slice is a repeating image of the 8 KB.

A write to a control input chooses how the fold works. In low-index mode, address bit 13 picks the half. In high-index mode, address bit 25 picks it. A third setting turns the window off, and then nothing in the slice reaches the SRAM.

Bus accesses give a 32-bit word address, read and write strobes, byte enables and write data. One cycle later the block returns a hit flag and, for reads, the data word. Accesses that miss the window, or arrive while the window is off, leave the SRAM untouched and report no hit.

Top module: `ocram_window`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `bus_hit` is 0, `bus_rdata` is 0 and the window is off.
- R2: An access hits only when address bits [31:26] equal 6'b000111, which is the range 0x1C000000 to 0x1FFFFFFF. An access outside that range gives `bus_hit` 0 and leaves the SRAM unchanged. A read outside the range returns 0.
- R3: A cycle with `ctl_wr` high loads the mode from `ctl_wdata`. Bit 0 is the enable and bit 1 is the index select. Enable 0 means off. Enable 1 with select 0 means low-index mode, and enable 1 with select 1 means high-index mode. All other bits are ignored. The new mode applies from the next cycle, so an access in the same cycle as the write uses the old mode.
- R4: In low-index mode, address bit 13 selects the half: 0 selects half 0 and 1 selects half 1.
- R5: In high-index mode, address bit 25 selects the half: 0 selects half 0 and 1 selects half 1.
- R6: Address bits [11:2] select the 32-bit word inside the chosen half. All other address bits below bit 26, apart from the active select bit, are ignored, so their aliases reach the same word.
- R7: During a write hit, `bus_be[i]` set to 1 replaces byte lane i (data bits 8i+7 to 8i). Lanes whose enable is 0 keep their old contents.
- R8: While the window is off, no access hits and writes leave the SRAM unchanged. Reads return 0.
- R9: `bus_hit` and read data appear on the cycle after the strobe. `bus_rdata` keeps its value on cycles without a read. A read issued together with a write returns the word as it was before the write.
- R10: Changing the mode, including turning the window off, does not alter the SRAM contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 32 | Control write data (bit 0 enable, bit 1 index select) |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_be | input | 4 | Byte-lane write enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after a read |
| bus_hit | output | 1 | The previous cycle's access reached the SRAM |

## Verification
Some properties are checked on every cycle by assertions:
- a hit always comes from an access that was in the window while the window was on;
- at most one half is written per cycle;
- the mode changes only on a control write;
- a missed read returns zero;
- the read data holds between reads;
- a lane just written reads back its new byte.

Other behaviour can only be shown by the bench's scenarios:
- which half each mode picks;
- that aliased addresses reach the same word;
- that rejected writes really leave the SRAM unchanged;
- that a control write applies only to later accesses;
- that contents survive mode changes.

The bench shows these by comparing against a behavioural model and by reading the SRAM back.

// File: rtl/ocram_window_pkg.sv
// Package: shared types for the on-chip RAM address window.
// Assumes nothing beyond IEEE 1800-2017; holds the mode encoding only.
package ocram_window_pkg;

    // Window mode: off, half chosen by the low select bit, or by the high one.
    typedef enum logic [1:0] {
        WIN_OFF  = 2'd0,
        WIN_LOW  = 2'd1,
        WIN_HIGH = 2'd2
    } win_mode_e;

endpackage

// File: rtl/ocram_window_ctl.sv
// Module: ocram_window_ctl
// Holds the window mode. Loads it from two bits of the control write data.
// Assumes the write strobe is synchronous to clk; all other data bits are
// deliberately ignored.
module ocram_window_ctl
    import ocram_window_pkg::*;
#(
    parameter int CTL_W       = 32,
    parameter int CTL_ENA_BIT = 0,
    parameter int CTL_IDX_BIT = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic [CTL_W-1:0] ctl_wdata,
    output win_mode_e        mode
);

    win_mode_e mode_q;
    win_mode_e mode_nxt;
    logic      unused_ctl_bits;

    // Decode the two meaningful control bits into a mode.
    always_comb begin
        if (!ctl_wdata[CTL_ENA_BIT]) begin
            mode_nxt = WIN_OFF;
        end else if (ctl_wdata[CTL_IDX_BIT]) begin
            mode_nxt = WIN_HIGH;
        end else begin
            mode_nxt = WIN_LOW;
        end
    end

    // Mode register: cleared by reset, loaded on a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= WIN_OFF;
        end else if (ctl_wr) begin
            mode_q <= mode_nxt;
        end
    end

    assign mode            = mode_q;
    assign unused_ctl_bits = ^ctl_wdata;

    // The mode only moves when a control write happened the cycle before.
    assert_mode_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_wr) |-> $stable(mode_q));

endmodule

// File: rtl/ocram_window_decode.sv
// Module: ocram_window_decode
// Combinational decode of a bus address against the window.
// Produces the in-window flag, the "maps to RAM" flag, the half select
// and the word index. Assumes word-aligned accesses; the byte offset bits
// below the word are ignored.
module ocram_window_decode
    import ocram_window_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h1C00_0000,
    parameter int                WIN_SPAN_BITS = 26,
    parameter int                PAGE_BITS     = 12,
    parameter int                OFF_LSB       = 2,
    parameter int                LOW_SEL_BIT   = 13,
    parameter int                HIGH_SEL_BIT  = 25,
    localparam int               WORD_BITS     = PAGE_BITS - OFF_LSB
) (
    input  logic [ADDR_W-1:0]    addr,
    input  win_mode_e            mode,
    output logic                 in_win,
    output logic                 map_ok,
    output logic                 half,
    output logic [WORD_BITS-1:0] word_idx
);

    logic unused_addr_bits;

    // Window match on the bits above the window span.
    always_comb begin
        in_win = (addr[ADDR_W-1:WIN_SPAN_BITS] == WIN_BASE[ADDR_W-1:WIN_SPAN_BITS]);
        map_ok = in_win && (mode != WIN_OFF);
    end

    // Half select: the mode picks which address bit folds the window.
    always_comb begin
        unique case (mode)
            WIN_HIGH: half = addr[HIGH_SEL_BIT];
            WIN_LOW:  half = addr[LOW_SEL_BIT];
            default:  half = 1'b0;
        endcase
    end

    assign word_idx         = addr[PAGE_BITS-1:OFF_LSB];
    assign unused_addr_bits = ^addr;

endmodule

// File: rtl/ocram_window_bank.sv
// Module: ocram_window_bank
// One 4 KB half of the SRAM, built as byte lanes with their own write
// enables. The read is asynchronous: the response stage registers it, so a
// same-cycle write is seen only by later reads. Contents are not reset.
module ocram_window_bank #(
    parameter int  DATA_W    = 32,
    parameter int  WORD_BITS = 10,
    localparam int BE_W      = DATA_W / 8,
    localparam int DEPTH     = 1 << WORD_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [BE_W-1:0]      be,
    input  logic [WORD_BITS-1:0] word_idx,
    input  logic [DATA_W-1:0]    wdata,
    output logic [DATA_W-1:0]    rd_word
);

    for (genvar ln = 0; ln < BE_W; ln++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        // Byte-lane write: only lanes whose enable is set change.
        always_ff @(posedge clk) begin
            if (we && be[ln]) begin
                lane_mem[word_idx] <= wdata[8*ln +: 8];
            end
        end

        // Asynchronous lane read at the current word index.
        assign rd_word[8*ln +: 8] = lane_mem[word_idx];

        // A lane just written reads back the written byte at that index.
        assert_lane_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(we && be[ln]) && (word_idx == $past(word_idx)))
            |-> (rd_word[8*ln +: 8] == $past(wdata[8*ln +: 8])));
    end

endmodule

// File: rtl/ocram_window_resp.sv
// Module: ocram_window_resp
// Response stage. Registers the hit flag and the read data, one cycle after
// the strobe. A read that misses returns zero; the data holds when no read
// happens. Assumes the bank words are valid in the cycle of the strobe.
module ocram_window_resp #(
    parameter int  DATA_W     = 32,
    parameter int  NUM_HALVES = 2
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             acc,
    input  logic                             rd,
    input  logic                             map_ok,
    input  logic                             half,
    input  logic [NUM_HALVES-1:0][DATA_W-1:0] bank_word,
    output logic                             hit,
    output logic [DATA_W-1:0]                rdata
);

    logic [DATA_W-1:0] sel_word;
    logic              hit_q;
    logic [DATA_W-1:0] rdata_q;

    // Pick the word of the selected half.
    assign sel_word = bank_word[half];

    // Hit register: set for any strobe that reached the RAM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else begin
            hit_q <= acc && map_ok;
        end
    end

    // Read data register: loaded on reads, zero on a missed read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd) begin
            rdata_q <= map_ok ? sel_word : '0;
        end
    end

    assign hit   = hit_q;
    assign rdata = rdata_q;

endmodule

// File: rtl/ocram_window.sv
// Module: ocram_window (top)
// Maps the address window onto two 4 KB SRAM halves. The active mode picks
// the half with one address bit, so the whole window aliases onto 8 KB.
// Assumes 32-bit word accesses with byte enables. Hit and read data follow
// the strobe by one cycle.
module ocram_window
    import ocram_window_pkg::*;
#(
    parameter int                ADDR_W        = 32,
    parameter int                DATA_W        = 32,
    parameter int                CTL_W         = 32,
    parameter int                PAGE_BITS     = 12,
    parameter logic [ADDR_W-1:0] WIN_BASE      = 32'h1C00_0000,
    parameter int                WIN_SPAN_BITS = 26,
    parameter int                LOW_SEL_BIT   = 13,
    parameter int                HIGH_SEL_BIT  = 25,
    parameter int                CTL_ENA_BIT   = 0,
    parameter int                CTL_IDX_BIT   = 1,
    localparam int               BE_W          = DATA_W / 8,
    localparam int               OFF_LSB       = $clog2(BE_W),
    localparam int               WORD_BITS     = PAGE_BITS - OFF_LSB,
    localparam int               NUM_HALVES    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_wr,
    input  logic [CTL_W-1:0]  ctl_wdata,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BE_W-1:0]   bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit
);

    win_mode_e                        cur_mode;
    logic                             dec_in_win;
    logic                             dec_map_ok;
    logic                             dec_half;
    logic [WORD_BITS-1:0]             dec_word;
    logic [NUM_HALVES-1:0]            bank_we;
    logic [NUM_HALVES-1:0][DATA_W-1:0] bank_word;
    logic                             acc;

    assign acc = bus_rd || bus_wr;

    ocram_window_ctl #(
        .CTL_W       (CTL_W),
        .CTL_ENA_BIT (CTL_ENA_BIT),
        .CTL_IDX_BIT (CTL_IDX_BIT)
    ) i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .mode      (cur_mode)
    );

    ocram_window_decode #(
        .ADDR_W        (ADDR_W),
        .WIN_BASE      (WIN_BASE),
        .WIN_SPAN_BITS (WIN_SPAN_BITS),
        .PAGE_BITS     (PAGE_BITS),
        .OFF_LSB       (OFF_LSB),
        .LOW_SEL_BIT   (LOW_SEL_BIT),
        .HIGH_SEL_BIT  (HIGH_SEL_BIT)
    ) i_decode (
        .addr     (bus_addr),
        .mode     (cur_mode),
        .in_win   (dec_in_win),
        .map_ok   (dec_map_ok),
        .half     (dec_half),
        .word_idx (dec_word)
    );

    for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
        // Write strobe for this half only when the access maps here.
        assign bank_we[h] = bus_wr && dec_map_ok && (dec_half == h[0]);

        ocram_window_bank #(
            .DATA_W    (DATA_W),
            .WORD_BITS (WORD_BITS)
        ) i_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .we       (bank_we[h]),
            .be       (bus_be),
            .word_idx (dec_word),
            .wdata    (bus_wdata),
            .rd_word  (bank_word[h])
        );
    end

    ocram_window_resp #(
        .DATA_W     (DATA_W),
        .NUM_HALVES (NUM_HALVES)
    ) i_resp (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (acc),
        .rd        (bus_rd),
        .map_ok    (dec_map_ok),
        .half      (dec_half),
        .bank_word (bank_word),
        .hit       (bus_hit),
        .rdata     (bus_rdata)
    );

    // A hit only follows an access whose address was inside the window.
    assert_hit_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> $past(dec_in_win));

    // A missed read returns zero data.
    assert_miss_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bus_rd) && !bus_hit) |-> (bus_rdata == '0));

    // At most one half is written in any cycle.
    assert_one_half_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_we));

    // No hit can come from an access made while the window was off.
    assert_no_hit_when_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> ($past(cur_mode) != WIN_OFF));

    // A hit is always the answer to a strobe one cycle earlier.
    assert_hit_after_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> $past(acc));

    // Read data holds on cycles that follow no read.
    assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bus_rd) |-> $stable(bus_rdata));

endmodule

// File: tb/test_ocram_window.sv
// Bench for ocram_window. A behavioural model (an int array and a few
// variables) is updated on every rising edge. The outputs are compared with
// it on every falling edge, and directed reads check known values.
module test_ocram_window;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_wr = 1'b0;
    logic [31:0] ctl_wdata = '0;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_hit;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R9";

    // Reference model state
    int unsigned ref_mem [2048];
    int          m_mode = 0;       // 0 off, 1 low, 2 high
    bit          e_hit = 1'b0;
    logic [31:0] e_rdata = '0;
    bit          m_ok;
    bit          m_half;
    int          m_idx;

    always #5 clk = ~clk;

    ocram_window i_ocram_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_hit   (bus_hit)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural model: uses the inputs seen at each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode  = 0;
            e_hit   = 1'b0;
            e_rdata = '0;
        end else begin
            m_ok   = (bus_addr[31:26] == 6'h07) && (m_mode != 0);
            m_half = (m_mode == 2) ? bus_addr[25] : bus_addr[13];
            m_idx  = int'({m_half, bus_addr[11:2]});
            e_hit  = (bus_rd || bus_wr) && m_ok;
            if (bus_rd) e_rdata = m_ok ? ref_mem[m_idx] : 32'h0;
            if (bus_wr && m_ok) begin
                for (int b = 0; b < 4; b++) begin
                    if (bus_be[b]) ref_mem[m_idx][8*b +: 8] = bus_wdata[8*b +: 8];
                end
            end
            if (ctl_wr) m_mode = !ctl_wdata[0] ? 0 : (ctl_wdata[1] ? 2 : 1);
        end
    end

    // Compare outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            chk({cur_req, " hit"}, {31'h0, bus_hit}, {31'h0, e_hit});
            chk({cur_req, " rdata"}, bus_rdata, e_rdata);
        end
    end

    task automatic drive(input bit rd, input bit wr, input logic [31:0] a,
                         input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = a; bus_be = be; bus_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic set_ctl(input logic [31:0] v);
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic wr_word(input logic [31:0] a, input logic [3:0] be, input logic [31:0] d);
        drive(1'b0, 1'b1, a, be, d);
        idle();
    endtask

    task automatic rd_chk(input string req, input logic [31:0] a,
                          input bit exp_hit, input logic [31:0] exp_data);
        drive(1'b1, 1'b0, a, 4'h0, 32'h0);
        idle();
        chk(req, {31'h0, bus_hit}, {31'h0, exp_hit});
        chk(req, bus_rdata, exp_data);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        // R1: outputs during reset and on the first cycle after release
        repeat (3) @(negedge clk);
        chk("R1 hit in reset", {31'h0, bus_hit}, 32'h0);
        chk("R1 rdata in reset", bus_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hit after reset", {31'h0, bus_hit}, 32'h0);
        cmp_on = 1'b1;
        cur_req = "R1";
        rd_chk("R1 window off after reset", 32'h1C00_0000, 1'b0, 32'h0);

        // R3: extra control bits ignored; bit0=1, bit1=0 -> low-index mode
        cur_req = "R3";
        set_ctl(32'hFFFF_FFF9);
        for (int i = 0; i < 2048; i++) begin
            drive(1'b0, 1'b1, 32'h1C00_0000 | (32'(i >> 10) << 13) | (32'(i & 1023) << 2),
                  4'hF, 32'h5A00_0000 ^ 32'(i));
        end
        idle();
        rd_chk("R3 low mode active", 32'h1C00_0004, 1'b1, 32'h5A00_0001);

        // R6: bits 25 and 12 ignored in low mode -> alias of word 1, half 0
        cur_req = "R6";
        rd_chk("R6 alias", 32'h1E00_1004, 1'b1, 32'h5A00_0001);
        // R4: bit 13 set -> half 1, word 2 = index 1026
        cur_req = "R4";
        rd_chk("R4 bit13 half1", 32'h1C00_2008, 1'b1, 32'h5A00_0402);
        rd_chk("R4 top of window", 32'h1FFF_FFFC, 1'b1, 32'h5A00_07FF);

        // R7: lanes 0 and 2 of word 4 replaced
        cur_req = "R7";
        wr_word(32'h1C00_0010, 4'b0101, 32'h1122_3344);
        rd_chk("R7 byte lanes", 32'h1C00_0010, 1'b1, 32'h5A22_0044);

        // R2: writes just outside both edges of the window
        cur_req = "R2";
        drive(1'b0, 1'b1, 32'h1BFF_FFFC, 4'hF, 32'hDEAD_BEEF);
        idle();
        chk("R2 no hit below window", {31'h0, bus_hit}, 32'h0);
        wr_word(32'h2000_0000, 4'hF, 32'hDEAD_BEEF);
        rd_chk("R2 read above window", 32'h2000_0000, 1'b0, 32'h0);
        rd_chk("R2 RAM unchanged", 32'h1C00_0000, 1'b1, 32'h5A00_0000);
        rd_chk("R2 RAM unchanged top", 32'h1C00_2FFC, 1'b1, 32'h5A00_07FF);

        // R5: high-index mode, bit 25 picks the half
        cur_req = "R5";
        set_ctl(32'h0000_0003);
        rd_chk("R5 bit25 half1", 32'h1E00_0008, 1'b1, 32'h5A00_0402);
        rd_chk("R5 bit13 ignored", 32'h1C00_2008, 1'b1, 32'h5A00_0002);

        // R3: a control write in the same cycle as a read uses the old mode
        cur_req = "R3";
        @(negedge clk);
        ctl_wr = 1'b1; ctl_wdata = 32'h0; bus_rd = 1'b1; bus_addr = 32'h1C00_0008;
        @(negedge clk);
        ctl_wr = 1'b0; bus_rd = 1'b0;
        chk("R3 old mode applies", bus_rdata, 32'h5A00_0002);
        rd_chk("R3 new mode off", 32'h1C00_0008, 1'b0, 32'h0);

        // R8: window off (select set, enable clear); write ignored
        cur_req = "R8";
        set_ctl(32'h0000_0002);
        drive(1'b0, 1'b1, 32'h1C00_000C, 4'hF, 32'hFFFF_FFFF);
        idle();
        chk("R8 no write hit", {31'h0, bus_hit}, 32'h0);
        rd_chk("R8 read off", 32'h1C00_000C, 1'b0, 32'h0);

        // R10: contents survive the mode changes
        cur_req = "R10";
        set_ctl(32'h0000_0001);
        rd_chk("R10 contents kept", 32'h1C00_000C, 1'b1, 32'h5A00_0003);

        // R9: data holds with no read; read with write returns the old word
        cur_req = "R9";
        held = bus_rdata;
        repeat (3) idle();
        chk("R9 rdata held", bus_rdata, held);
        drive(1'b1, 1'b1, 32'h1C00_0014, 4'hF, 32'h0BAD_F00D);
        idle();
        chk("R9 read before write", bus_rdata, 32'h5A00_0005);
        rd_chk("R9 write landed", 32'h1C00_0014, 1'b1, 32'h0BAD_F00D);

        // Mixed traffic, compared each cycle against the model
        cur_req = "R6";
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] a;
            a = $urandom;
            if (($urandom % 4) != 0) a[31:26] = 6'h07;
            a[1:0] = 2'b00;
            if (($urandom % 200) == 0) begin
                @(negedge clk);
                ctl_wr = 1'b1; ctl_wdata = $urandom;
                bus_rd = 1'b0; bus_wr = 1'b0;
                @(negedge clk);
                ctl_wr = 1'b0;
            end
            drive(1'($urandom), 1'($urandom), a, 4'($urandom), $urandom);
        end
        idle();
        idle();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule